// File: doc/BRIEF.md
# Per-Pin Interrupt Detector

This block watches a bank of input pins and turns their levels into interrupt events. Each pin is brought into the clock domain by a short flop chain. It then passes through a detector that you configure per pin. The detector can work on a level, of either polarity, or on an edge: rising, falling, or any change. Edge events are held in a latch until software acknowledges them. Level events simply follow the pin.

Two status views are readable. The raw view shows the detector outputs before masking. The masked view shows them after masking. The OR of the masked view drives a single registered interrupt line.

Software reaches the configuration through 32-bit words that each cover sixteen pins. In every write word, the upper sixteen bits select which of the lower sixteen bits take effect. This lets one pin be changed without a read-modify-write. The word at an offset covers pins 0..15, and the word at offset+4 covers pins 16..31.

Top module: `pin_irq_unit`

## Requirements
- R1: A write to a configuration word changes only those bits n (0..15) whose select bit n+16 is 1. Each such bit takes write bit n. A word at base+4 covers pins 16..31. Every read returns the sixteen addressed bits in bits 15:0, with bits 31:16 reading zero.
- R2: The word bases are: detection enable 0x10, mask 0x18, trigger kind 0x20, polarity 0x28, any-edge 0x30, masked status 0x50, raw status 0x58, acknowledge 0x60. Each configuration word reads back what was written to it and is independent of the others.
- R3: A pin whose enable bit is 0 shows 0 in raw status and latches no event. After enable is set again, no stale event appears.
- R4: With trigger kind 0 (level), raw status is 1 exactly while the synchronised pin equals its polarity bit: polarity 1 means active high, polarity 0 means active low. Nothing is latched.
- R5: With trigger kind 1 (edge) and any-edge 0, a rising edge (polarity 1) or a falling edge (polarity 0) sets the raw bit. The bit stays set after the pin moves back.
- R6: With trigger kind 1 and any-edge 1, either edge sets the raw bit, whatever the polarity bit is.
- R7: Masked status equals raw status AND NOT mask. A mask bit of 1 leaves raw status untouched.
- R8: A selected acknowledge bit written as 1 clears that pin's latched edge event. A selected bit written as 0 clears nothing. An acknowledge has no effect on a level-kind pin.
- R9: When an edge event and an acknowledge for the same pin fall in the same cycle, the bit stays set.
- R10: The interrupt output is the OR of masked status, delayed by one register stage.
- R11: After reset, every configuration word, both status views and the interrupt output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | NPINS | Asynchronous pin levels |
| reg_we | input | 1 | Write strobe for the addressed word |
| reg_addr | input | ADDR_W | Byte address of the word |
| reg_wdata | input | 32 | Write data: select mask in 31:16, values in 15:0 |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The edge-hold property assumes that a latched edge event can only be released by a register write. An acknowledge, or a change to enable or trigger kind, all need reg_we. The property therefore only looks at cycles with no write. The bench holds reg_we low outside single-cycle writes driven on the falling edge. It moves pins only on falling edges, well clear of the sampling edge. Before every check it waits at least the synchroniser and latch latency. The one exception is the same-cycle acknowledge test, where the bench places the write deliberately in the event cycle.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
   localparam int HALF_W   = 16;
   localparam int WORD_W   = 32;
   localparam int NUM_CFG  = 5;

   // configuration register indices
   localparam int CFG_EN   = 0;
   localparam int CFG_MASK = 1;
   localparam int CFG_TYPE = 2;
   localparam int CFG_POL  = 3;
   localparam int CFG_BOTH = 4;

   // status / action word bases
   localparam int OFF_MSTAT = 'h50;
   localparam int OFF_RAW   = 'h58;
   localparam int OFF_ACK   = 'h60;
   localparam int HALF_STEP = 4;

   function automatic int cfg_offset(input int idx);
      case (idx)
         CFG_EN:   return 'h10;
         CFG_MASK: return 'h18;
         CFG_TYPE: return 'h20;
         CFG_POL:  return 'h28;
         default:  return 'h30;
      endcase
   endfunction
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 0) begin : g_bad
         $error("pin_irq_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q[0] <= d_i;
               for (int s = 1; s < STAGES; s++) begin
                  chain_q[s] <= chain_q[s-1];
               end
            end
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
   import pin_irq_pkg::*;
#(
   parameter int NPINS  = 32,
   parameter int ADDR_W = 8
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               we_i,
   input  logic [ADDR_W-1:0]                  addr_i,
   input  logic [WORD_W-1:0]                  wdata_i,
   input  logic [NPINS-1:0]                   raw_i,
   input  logic [NPINS-1:0]                   msk_i,
   output logic [NUM_CFG-1:0][NPINS-1:0]      cfg_o,
   output logic [NPINS-1:0]                   ack_o,
   output logic [WORD_W-1:0]                  rdata_o
);
   localparam int NHALF = NPINS / HALF_W;

   logic [HALF_W-1:0] wr_val;
   logic [HALF_W-1:0] wr_sel;
   assign wr_val = wdata_i[HALF_W-1:0];
   assign wr_sel = wdata_i[WORD_W-1:HALF_W];

   generate
      for (genvar c = 0; c < NUM_CFG; c++) begin : g_cfg
         for (genvar h = 0; h < NHALF; h++) begin : g_half
            localparam int BASE = cfg_offset(c) + HALF_STEP * h;
            logic              hit;
            logic [HALF_W-1:0] half_q;
            assign hit = we_i && (addr_i == ADDR_W'(BASE));
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  half_q <= '0;
               end else if (hit) begin
                  half_q <= (half_q & ~wr_sel) | (wr_val & wr_sel);
               end
            end
            assign cfg_o[c][h*HALF_W +: HALF_W] = half_q;
         end
      end

      for (genvar h = 0; h < NHALF; h++) begin : g_ack
         localparam int ABASE = OFF_ACK + HALF_STEP * h;
         logic ack_hit;
         assign ack_hit = we_i && (addr_i == ADDR_W'(ABASE));
         assign ack_o[h*HALF_W +: HALF_W] = ack_hit ? (wr_val & wr_sel) : '0;
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      for (int h = 0; h < NHALF; h++) begin
         for (int c = 0; c < NUM_CFG; c++) begin
            if (addr_i == ADDR_W'(cfg_offset(c) + HALF_STEP * h)) begin
               rdata_o = {{(WORD_W-HALF_W){1'b0}}, cfg_o[c][h*HALF_W +: HALF_W]};
            end
         end
         if (addr_i == ADDR_W'(OFF_RAW + HALF_STEP * h)) begin
            rdata_o = {{(WORD_W-HALF_W){1'b0}}, raw_i[h*HALF_W +: HALF_W]};
         end
         if (addr_i == ADDR_W'(OFF_MSTAT + HALF_STEP * h)) begin
            rdata_o = {{(WORD_W-HALF_W){1'b0}}, msk_i[h*HALF_W +: HALF_W]};
         end
      end
   end
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect #(
   parameter int NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] lvl_i,
   input  logic [NPINS-1:0] en_i,
   input  logic [NPINS-1:0] edge_i,
   input  logic [NPINS-1:0] pol_i,
   input  logic [NPINS-1:0] any_i,
   input  logic [NPINS-1:0] ack_i,
   output logic [NPINS-1:0] raw_o
);
   generate
      for (genvar p = 0; p < NPINS; p++) begin : g_pin
         logic prev_q;
         logic hold_q;
         logic rise;
         logic fall;
         logic evt;
         logic armed;

         assign rise  = lvl_i[p] & ~prev_q;
         assign fall  = ~lvl_i[p] & prev_q;
         assign evt   = any_i[p] ? (rise | fall) : (pol_i[p] ? rise : fall);
         assign armed = en_i[p] & edge_i[p];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               hold_q <= 1'b0;
            end else begin
               prev_q <= lvl_i[p];
               // a fresh event outranks an acknowledge in the same cycle
               hold_q <= armed & (evt | (hold_q & ~ack_i[p]));
            end
         end

         assign raw_o[p] = en_i[p] & (edge_i[p] ? hold_q : (lvl_i[p] ~^ pol_i[p]));
      end
   endgenerate
endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
   import pin_irq_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPINS-1:0]  pins_i,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq_o
);
   generate
      if (NPINS < HALF_W || NPINS > 2 * HALF_W || (NPINS % HALF_W) != 0) begin : g_bad_pins
         $error("pin_irq_unit: NPINS must be 16 or 32");
      end
      if (ADDR_W < 7) begin : g_bad_addr
         $error("pin_irq_unit: ADDR_W too small for the register window");
      end
   endgenerate

   logic [NPINS-1:0]                lvl_w;
   logic [NUM_CFG-1:0][NPINS-1:0]   cfg_w;
   logic [NPINS-1:0]                ack_w;
   logic [NPINS-1:0]                en_w;
   logic [NPINS-1:0]                mask_w;
   logic [NPINS-1:0]                typ_w;
   logic [NPINS-1:0]                raw_w;
   logic [NPINS-1:0]                msk_w;
   logic                            irq_q;

   pin_irq_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pins_i),
      .q_o   (lvl_w)
   );

   pin_irq_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (reg_we),
      .addr_i  (reg_addr),
      .wdata_i (reg_wdata),
      .raw_i   (raw_w),
      .msk_i   (msk_w),
      .cfg_o   (cfg_w),
      .ack_o   (ack_w),
      .rdata_o (reg_rdata)
   );

   assign en_w   = cfg_w[CFG_EN];
   assign mask_w = cfg_w[CFG_MASK];
   assign typ_w  = cfg_w[CFG_TYPE];

   pin_irq_detect #(.NPINS(NPINS)) u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (lvl_w),
      .en_i   (en_w),
      .edge_i (typ_w),
      .pol_i  (cfg_w[CFG_POL]),
      .any_i  (cfg_w[CFG_BOTH]),
      .ack_i  (ack_w),
      .raw_o  (raw_w)
   );

   assign msk_w = raw_w & ~mask_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |msk_w;
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/pin_irq_unit_chk.sv
module pin_irq_unit_chk #(
   parameter int NPINS = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic [NPINS-1:0] en_w,
   input logic [NPINS-1:0] typ_w,
   input logic [NPINS-1:0] mask_w,
   input logic [NPINS-1:0] raw_w,
   input logic [NPINS-1:0] msk_w,
   input logic             irq_o
);
   a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_w & ~en_w) == '0);

   a_r7_mask_hides: assert property (@(posedge clk) disable iff (!rst_n)
      (msk_w & mask_w) == '0);

   a_r7_masked_subset: assert property (@(posedge clk) disable iff (!rst_n)
      (msk_w & ~raw_w) == '0);

   a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (|msk_w) |=> irq_o);

   a_r10_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !(|msk_w) |=> !irq_o);

   a_r5_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_we |=> ((raw_w & $past(raw_w & typ_w & en_w)) == $past(raw_w & typ_w & en_w)));
endmodule

bind pin_irq_unit pin_irq_unit_chk #(.NPINS(NPINS)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .reg_we (reg_we),
   .en_w   (en_w),
   .typ_w  (typ_w),
   .mask_w (mask_w),
   .raw_w  (raw_w),
   .msk_w  (msk_w),
   .irq_o  (irq_o)
);

// File: tb/tb_pin_irq_unit.sv
`timescale 1ns/1ps
module tb_pin_irq_unit;
   localparam int A_EN = 'h10, A_MASK = 'h18, A_TYPE = 'h20, A_POL = 'h28, A_BOTH = 'h30;
   localparam int A_MST = 'h50, A_RAW = 'h58, A_ACK = 'h60;

   // {type, pol, both, pin_before, pin_after, expected_raw}
   localparam logic [5:0] VEC [12] = '{
      6'b010011, 6'b010100, 6'b000101, 6'b000010,
      6'b110011, 6'b110100, 6'b100101, 6'b100010,
      6'b101011, 6'b111101, 6'b011011, 6'b011100 };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pins = '0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_o;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   pin_irq_unit dut (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o));

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 8'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = 8'(a);
      #1 d = reg_rdata;
   endtask

   task automatic setbit(input int base, input int pin, input bit v);
      wr(base + ((pin >= 16) ? 4 : 0), (32'h1 << (pin % 16 + 16)) | (32'(v) << (pin % 16)));
   endtask

   task automatic rdbit(input int base, input int pin, output logic b);
      logic [31:0] d;
      rd(base + ((pin >= 16) ? 4 : 0), d);
      b = d[pin % 16];
   endtask

   task automatic cleanup();
      for (int k = 0; k < 5; k++) begin
         wr(A_EN + 8 * k, 32'hFFFF_0000);
         wr(A_EN + 8 * k + 4, 32'hFFFF_0000);
      end
      pins = '0;
      repeat (6) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic        b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11: reset state
      for (int k = 0; k < 8; k++) begin
         rd(A_EN + 8 * k, d);
         chk("R11", "reset word", d, 32'h0);
      end
      rd(A_RAW + 4, d); chk("R11", "reset raw hi", d, 32'h0);
      chk("R11", "reset irq", 32'(irq_o), 32'h0);

      // R1: half-word selective writes
      wr(A_EN, 32'h00FF_FFFF);
      rd(A_EN, d); chk("R1", "select low byte", d, 32'h0000_00FF);
      wr(A_EN, 32'h0003_0000);
      rd(A_EN, d); chk("R1", "clear two bits", d, 32'h0000_00FC);
      wr(A_EN + 4, 32'hFFFF_1234);
      rd(A_EN + 4, d); chk("R1", "upper half word", d, 32'h0000_1234);
      rd(A_EN, d); chk("R1", "lower half untouched", d, 32'h0000_00FC);

      // R2: each configuration word is separately decoded
      for (int k = 0; k < 5; k++) wr(A_EN + 8 * k, 32'hFFFF_0000 | 32'(16'h1111 * (k + 1)));
      for (int k = 0; k < 5; k++) begin
         rd(A_EN + 8 * k, d);
         chk("R2", "word readback", d, 32'(16'h1111 * (k + 1)));
      end
      cleanup();

      // R4 / R5 / R6 / R10: table of trigger settings on pin 0
      for (int i = 0; i < 12; i++) begin
         logic [5:0] v;
         string      tag;
         v   = VEC[i];
         tag = v[5] ? (v[3] ? "R6" : "R5") : "R4";
         setbit(A_TYPE, 0, v[5]);
         setbit(A_POL, 0, v[4]);
         setbit(A_BOTH, 0, v[3]);
         setbit(A_EN, 0, 1'b1);
         @(negedge clk); pins[0] = v[2];
         repeat (6) @(negedge clk);
         wr(A_ACK, 32'h0001_0001);
         @(negedge clk); pins[0] = v[1];
         repeat (6) @(negedge clk);
         rdbit(A_RAW, 0, b);
         chk(tag, $sformatf("vector %0d raw", i), 32'(b), 32'(v[0]));
         chk("R10", $sformatf("vector %0d irq", i), 32'(irq_o), 32'(v[0]));
      end
      cleanup();

      // R5: latched rising edge survives the pin falling back
      setbit(A_TYPE, 1, 1'b1); setbit(A_POL, 1, 1'b1); setbit(A_EN, 1, 1'b1);
      @(negedge clk); pins[1] = 1'b1;
      repeat (6) @(negedge clk); pins[1] = 1'b0;
      repeat (6) @(negedge clk);
      rdbit(A_RAW, 1, b); chk("R5", "edge held after return", 32'(b), 32'h1);
      cleanup();

      // R3: disabled pin ignores edges, no stale event after enabling
      setbit(A_TYPE, 6, 1'b1); setbit(A_POL, 6, 1'b1);
      @(negedge clk); pins[6] = 1'b1;
      repeat (6) @(negedge clk);
      rdbit(A_RAW, 6, b); chk("R3", "disabled raw", 32'(b), 32'h0);
      setbit(A_EN, 6, 1'b1);
      repeat (4) @(negedge clk);
      rdbit(A_RAW, 6, b); chk("R3", "no stale event", 32'(b), 32'h0);
      cleanup();

      // R7: mask hides the masked view only
      setbit(A_POL, 5, 1'b1); setbit(A_MASK, 5, 1'b1); setbit(A_EN, 5, 1'b1);
      @(negedge clk); pins[5] = 1'b1;
      repeat (6) @(negedge clk);
      rdbit(A_RAW, 5, b); chk("R7", "raw while masked", 32'(b), 32'h1);
      rdbit(A_MST, 5, b); chk("R7", "masked view", 32'(b), 32'h0);
      chk("R7", "irq while masked", 32'(irq_o), 32'h0);
      setbit(A_MASK, 5, 1'b0);
      repeat (3) @(negedge clk);
      rdbit(A_MST, 5, b); chk("R7", "unmasked view", 32'(b), 32'h1);
      chk("R10", "irq after unmask", 32'(irq_o), 32'h1);
      cleanup();

      // R10: one register stage between masked status and irq
      setbit(A_POL, 4, 1'b1); setbit(A_EN, 4, 1'b1);
      reg_addr = 8'(A_RAW);
      @(negedge clk); pins[4] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      #1;
      chk("R10", "raw visible", 32'(reg_rdata[4]), 32'h1);
      chk("R10", "irq not yet", 32'(irq_o), 32'h0);
      @(negedge clk);
      chk("R10", "irq one cycle later", 32'(irq_o), 32'h1);
      cleanup();

      // R8: acknowledge on upper-half edge pin 17 and level pin 18
      setbit(A_TYPE, 17, 1'b1); setbit(A_POL, 17, 1'b1); setbit(A_EN, 17, 1'b1);
      setbit(A_POL, 18, 1'b1); setbit(A_EN, 18, 1'b1);
      @(negedge clk); pins[17] = 1'b1; pins[18] = 1'b1;
      repeat (6) @(negedge clk);
      rdbit(A_RAW, 17, b); chk("R8", "edge latched", 32'(b), 32'h1);
      wr(A_ACK + 4, 32'h0002_0000);
      rdbit(A_RAW, 17, b); chk("R8", "ack with zero keeps", 32'(b), 32'h1);
      wr(A_ACK + 4, 32'h0006_0006);
      rdbit(A_RAW, 17, b); chk("R8", "ack clears edge", 32'(b), 32'h0);
      rdbit(A_RAW, 18, b); chk("R8", "ack ignores level", 32'(b), 32'h1);
      cleanup();

      // R9: acknowledge in the same cycle as a new edge
      setbit(A_TYPE, 3, 1'b1); setbit(A_POL, 3, 1'b1); setbit(A_EN, 3, 1'b1);
      repeat (4) @(negedge clk);
      @(negedge clk); pins[3] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 8'(A_ACK); reg_wdata = 32'h0008_0008;
      @(negedge clk);
      reg_we = 1'b0;
      repeat (2) @(negedge clk);
      rdbit(A_RAW, 3, b); chk("R9", "edge beats ack", 32'(b), 32'h1);
      wr(A_ACK, 32'h0008_0008);
      rdbit(A_RAW, 3, b); chk("R9", "later ack clears", 32'(b), 32'h0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule